// File: doc/BRIEF.md
# Dual-Bank Mersenne Twister Pair Generator

This block produces 32-bit uniformly distributed pseudo-random words with the 624-word twisted generalized feedback recurrence (offset 397) and the usual four-step output tempering. The sequence it produces is bit-exact to the standard 32-bit reference generator for the same seed. Software or a neighbouring engine loads a 32-bit seed. The block then fills its state serially with the standard initialization recurrence, one word per cycle. After that, a start pulse opens a continuous stream of word pairs.

The state is held in two memories. Words at even positions go in one and words at odd positions go in the other, so each memory needs only one read and one write port. Each two-cycle iteration regenerates two adjacent state words and tempers them at once. The result is one pair every two cycles, an average of one word per cycle. Ring positions advance by add-and-compare wraparound instead of a modulo. A new seed load aborts a running stream at any time.

Top module: `mt_pair_gen`

## Requirements
- R1: While reset is high and in the cycle after it is released, `seeded` and `pair_valid` are low.
- R2: A `seed_load` pulse drives `seeded` low on the next clock edge. `seeded` goes high again exactly 624 edges after the edge that sampled the load.
- R3: `start` is ignored while `seeded` is low: no pair is ever produced from it, even after seeding completes.
- R4: While running, `pair_valid` is high for one cycle and then low for one cycle, repeating without a gap.
- R5: For seed 5489, the first pair is 3499211612 (`rand_first`) and 581869302 (`rand_second`). The second pair is 3890346734 and 3586334585.
- R6: Output word n of the stream (n = 0, 1, 2, ...) equals output n of the standard generator for the loaded seed. This uses matrix constant 0x9908B0DF, upper mask 0x80000000, seeding multiplier 1812433253, and tempering shifts 11, 7 (mask 0x9D2C5680), 15 (mask 0xEFC60000) and 18. Each pair carries an even n in `rand_first` and n+1 in `rand_second`.
- R7: The stream stays exact after the first 624 outputs, across the regeneration of state words that were already rewritten in this pass.
- R8: A `seed_load` while running clears `pair_valid` from the next edge onward. After reseeding and a new start, the stream begins at output 0 of the new seed.
- R9: A `start` pulse while already running changes neither the values nor the two-cycle cadence.
- R10: After the edge that samples an accepted `start`, `pair_valid` first goes high on the third following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Pulse: capture `seed_value` and refill the state |
| seed_value | input | 32 | Seed word |
| start | input | 1 | Pulse: begin the output stream once seeded |
| seeded | output | 1 | State is filled and a stream may run |
| pair_valid | output | 1 | `rand_first`/`rand_second` hold a new pair |
| rand_first | output | 32 | Earlier word of the pair |
| rand_second | output | 32 | Later word of the pair |

## Verification
A wrong carried word, a swapped bank operand or a bad ring offset for the current pair appears in the very next pair, because every word is tempered in the same iteration that rewrites it. A state word corrupted during seeding or written to the wrong position may stay hidden until it is consumed as the far operand, up to 312 pairs later. For that reason the stream is compared word by word against an independent model past the 624th output. Cadence faults appear within two cycles as a missing or doubled strobe.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t TWIST_MAT = 32'h9908_B0DF;
    localparam word_t HI_MASK   = 32'h8000_0000;
    localparam word_t LO_MASK   = 32'h7FFF_FFFF;
    localparam word_t SEED_MULT = 32'd1812433253;
    localparam word_t TEMPER_B  = 32'h9D2C_5680;
    localparam word_t TEMPER_C  = 32'hEFC6_0000;

    typedef enum logic [1:0] {
        ST_BLANK,
        ST_FILL,
        ST_HOLD,
        ST_RUN
    } gen_state_t;

    typedef struct packed {
        word_t first;
        word_t second;
    } word_pair_t;

    // One step of the twist recurrence: top bit of hi_src, low bits of lo_src
    function automatic word_t mix_pair(word_t hi_src, word_t lo_src, word_t far_word);
        word_t y;
        y = (hi_src & HI_MASK) | (lo_src & LO_MASK);
        return far_word ^ (y >> 1) ^ (y[0] ? TWIST_MAT : '0);
    endfunction

    // Serial initializer step
    function automatic word_t seed_next(word_t prev, word_t pos);
        return (SEED_MULT * (prev ^ (prev >> 30))) + pos;
    endfunction

endpackage

// File: rtl/mt_bank.sv
module mt_bank #(
    parameter int unsigned DEPTH = 312,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  mt_pkg::word_t     wdata,
    input  logic [AW-1:0]     raddr,
    output mt_pkg::word_t     rdata
);
    mt_pkg::word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mt_temper.sv
module mt_temper #(
    parameter int unsigned SH_U = 11,
    parameter int unsigned SH_S = 7,
    parameter int unsigned SH_T = 15,
    parameter int unsigned SH_L = 18
) (
    input  mt_pkg::word_t raw,
    output mt_pkg::word_t cooked
);
    mt_pkg::word_t s1, s2, s3;

    always_comb begin
        s1     = raw ^ (raw >> SH_U);
        s2     = s1 ^ ((s1 << SH_S) & mt_pkg::TEMPER_B);
        s3     = s2 ^ ((s2 << SH_T) & mt_pkg::TEMPER_C);
        cooked = s3 ^ (s3 >> SH_L);
    end
endmodule

// File: rtl/mt_pair_gen.sv
module mt_pair_gen
    import mt_pkg::*;
#(
    parameter int unsigned N_WORDS = 624,
    parameter int unsigned SHIFT_M = 397
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic [31:0] seed_value,
    input  logic        start,
    output logic        seeded,
    output logic        pair_valid,
    output logic [31:0] rand_first,
    output logic [31:0] rand_second
);
    localparam int unsigned HALF  = N_WORDS / 2;
    localparam int unsigned AW    = $clog2(HALF);
    localparam int unsigned IW    = AW + 1;
    localparam int unsigned OFS_O = (SHIFT_M - 1) / 2;
    localparam int unsigned OFS_E = (SHIFT_M + 1) / 2;

    // Ring advance on a bank index without modulo
    function automatic logic [AW-1:0] ring_add(logic [AW-1:0] base, int unsigned ofs);
        logic [AW:0] s;
        s = {1'b0, base} + (AW+1)'(ofs);
        if (s >= (AW+1)'(HALF)) begin
            s = s - (AW+1)'(HALF);
        end
        return s[AW-1:0];
    endfunction

    gen_state_t  state;
    logic        phase;
    logic        primed;
    logic [AW-1:0] k;
    logic [AW-1:0] wr_k;
    logic [IW-1:0] fill_idx;
    word_t       fill_val;
    word_t       cur_e, cur_o, nxt_e;
    logic        valid_q;
    word_pair_t  pair_q;

    // bank 0 holds even positions, bank 1 odd positions
    logic [1:0]    bank_we;
    logic [AW-1:0] bank_waddr [2];
    word_t         bank_wdata [2];
    logic [AW-1:0] bank_raddr [2];
    word_t         bank_rdata [2];
    word_t         fresh      [2];
    word_t         tempered   [2];

    // fresh[0]: position 2k' from (2k', 2k'+1, far odd 2k'+397)
    // fresh[1]: position 2k'+1 from (2k'+1, 2k'+2, far even 2k'+398)
    always_comb begin
        fresh[0] = mix_pair(cur_e, cur_o, bank_rdata[1]);
        fresh[1] = mix_pair(cur_o, nxt_e, bank_rdata[0]);
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            mt_bank #(.DEPTH(HALF), .AW(AW)) u_bank (
                .clk   (clk),
                .we    (bank_we[b]),
                .waddr (bank_waddr[b]),
                .wdata (bank_wdata[b]),
                .raddr (bank_raddr[b]),
                .rdata (bank_rdata[b])
            );
            mt_temper u_temper (
                .raw    (fresh[b]),
                .cooked (tempered[b])
            );
        end
    endgenerate

    always_comb begin
        bank_we       = '0;
        bank_waddr[0] = '0;
        bank_waddr[1] = '0;
        bank_wdata[0] = '0;
        bank_wdata[1] = '0;
        bank_raddr[0] = '0;
        bank_raddr[1] = '0;
        if (!seed_load) begin
            case (state)
                ST_FILL: begin
                    bank_we[fill_idx[0]] = 1'b1;
                    bank_waddr[0]        = fill_idx[IW-1:1];
                    bank_waddr[1]        = fill_idx[IW-1:1];
                    bank_wdata[0]        = fill_val;
                    bank_wdata[1]        = fill_val;
                end
                ST_RUN: begin
                    if (!phase) begin
                        bank_raddr[0] = ring_add(k, 1);
                        bank_raddr[1] = k;
                        if (primed) begin
                            bank_we       = 2'b11;
                            bank_waddr[0] = wr_k;
                            bank_waddr[1] = wr_k;
                            bank_wdata[0] = fresh[0];
                            bank_wdata[1] = fresh[1];
                        end
                    end else begin
                        bank_raddr[0] = ring_add(k, OFS_E);
                        bank_raddr[1] = ring_add(k, OFS_O);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_BLANK;
            phase    <= 1'b0;
            primed   <= 1'b0;
            k        <= '0;
            wr_k     <= '0;
            fill_idx <= '0;
            fill_val <= '0;
            cur_e    <= '0;
            cur_o    <= '0;
            nxt_e    <= '0;
            valid_q  <= 1'b0;
            pair_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (seed_load) begin
                state    <= ST_FILL;
                fill_idx <= '0;
                fill_val <= seed_value;
            end else begin
                case (state)
                    ST_FILL: begin
                        if (fill_idx == '0) begin
                            cur_e <= fill_val;
                        end
                        fill_val <= seed_next(fill_val, WORD_W'(fill_idx) + 32'd1);
                        if (fill_idx == IW'(N_WORDS - 1)) begin
                            state <= ST_HOLD;
                        end else begin
                            fill_idx <= fill_idx + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (start) begin
                            state  <= ST_RUN;
                            phase  <= 1'b0;
                            primed <= 1'b0;
                            k      <= '0;
                        end
                    end
                    ST_RUN: begin
                        if (!phase) begin
                            phase <= 1'b1;
                            if (primed) begin
                                cur_e   <= nxt_e;
                                valid_q <= 1'b1;
                                pair_q  <= '{first: tempered[0], second: tempered[1]};
                            end
                        end else begin
                            phase  <= 1'b0;
                            nxt_e  <= bank_rdata[0];
                            cur_o  <= bank_rdata[1];
                            wr_k   <= k;
                            k      <= ring_add(k, 1);
                            primed <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign seeded      = (state == ST_HOLD) || (state == ST_RUN);
    assign pair_valid  = valid_q;
    assign rand_first  = pair_q.first;
    assign rand_second = pair_q.second;

endmodule

// File: rtl/mt_pair_gen_chk.sv
module mt_pair_gen_chk (
    input logic clk,
    input logic rst,
    input logic seed_load,
    input logic seeded,
    input logic pair_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pair_valid && !seeded));

    // R2
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !seeded);

    // R3
    valid_needs_seed_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> seeded);

    // R4
    pair_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // R4
    pair_cadence_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pair_valid) && !$past(seed_load) && !seed_load) |=> pair_valid);

    // R8
    load_stops_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !pair_valid);
endmodule

bind mt_pair_gen mt_pair_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .seed_load  (seed_load),
    .seeded     (seeded),
    .pair_valid (pair_valid)
);

// File: tb/mt_pair_gen_bench.sv
module mt_pair_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        start = 1'b0;
    logic        seeded, pair_valid;
    logic [31:0] rand_first, rand_second;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    mt_pair_gen u_mt_pair_gen (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .start(start), .seeded(seeded), .pair_valid(pair_valid),
        .rand_first(rand_first), .rand_second(rand_second)
    );

    // independent batch model of the standard generator
    logic [31:0] rm_st [624];
    int          rm_pos;

    task automatic rm_seed(input logic [31:0] s);
        rm_st[0] = s;
        for (int i = 1; i < 624; i++) begin
            rm_st[i] = 32'd1812433253 * (rm_st[i-1] ^ (rm_st[i-1] >> 30)) + 32'(i);
        end
        rm_pos = 624;
    endtask

    function automatic logic [31:0] rm_draw();
        logic [31:0] y;
        if (rm_pos >= 624) begin
            for (int i = 0; i < 624; i++) begin
                y = (rm_st[i] & 32'h8000_0000) | (rm_st[(i + 1) % 624] & 32'h7FFF_FFFF);
                rm_st[i] = rm_st[(i + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908_B0DF : 32'h0);
            end
            rm_pos = 0;
        end
        y = rm_st[rm_pos];
        rm_pos++;
        y = y ^ (y >> 11);
        y = y ^ ((y << 7) & 32'h9D2C_5680);
        y = y ^ ((y << 15) & 32'hEFC6_0000);
        y = y ^ (y >> 18);
        return y;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(seeded == 1'b0, "R1 seeded in reset", 32'(seeded), 0);
        chk(pair_valid == 1'b0, "R1 valid in reset", 32'(pair_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(seeded == 1'b0 && pair_valid == 1'b0, "R1 after release", 32'({seeded, pair_valid}), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(pair_valid == 1'b0, "R3 start unseeded", 32'(pair_valid), 0);
        end
    endtask

    // load a seed; optionally pulse start during the fill
    task automatic t_seed(input logic [31:0] s, input bit poke_start);
        seed_load  = 1'b1;
        seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        chk(seeded == 1'b0, "R2 seeded drops", 32'(seeded), 0);
        for (int i = 2; i <= 624; i++) begin
            @(negedge clk);
            start = (poke_start && i == 20);
        end
        chk(seeded == 1'b0, "R2 still filling at 623", 32'(seeded), 0);
        @(negedge clk);
        chk(seeded == 1'b1, "R2 seeded at 624", 32'(seeded), 1);
        rm_seed(s);
        if (poke_start) begin
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                chk(pair_valid == 1'b0, "R3 start during fill", 32'(pair_valid), 0);
            end
        end
    endtask

    task automatic t_start_latency();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(pair_valid == 1'b0, "R10 latency edge1", 32'(pair_valid), 0);
        @(negedge clk);
        chk(pair_valid == 1'b0, "R10 latency edge2", 32'(pair_valid), 0);
        @(negedge clk);
        chk(pair_valid == 1'b0, "R10 latency edge3", 32'(pair_valid), 0);
        @(negedge clk);
        chk(pair_valid == 1'b1, "R10 first pair", 32'(pair_valid), 1);
    endtask

    task automatic t_golden();
        logic [31:0] d;
        chk(rand_first == 32'd3499211612, "R5 word0", rand_first, 32'd3499211612);
        chk(rand_second == 32'd581869302, "R5 word1", rand_second, 32'd581869302);
        d = rm_draw();
        d = rm_draw();
        @(negedge clk);
        chk(pair_valid == 1'b0, "R4 gap", 32'(pair_valid), 0);
        @(negedge clk);
        chk(pair_valid == 1'b1, "R4 next pair", 32'(pair_valid), 1);
        chk(rand_first == 32'd3890346734, "R5 word2", rand_first, 32'd3890346734);
        chk(rand_second == 32'd3586334585, "R5 word3", rand_second, 32'd3586334585);
        d = rm_draw();
        d = rm_draw();
        @(negedge clk);
        @(negedge clk);
    endtask

    // compare npairs consecutive pairs; starts at a negedge with a pair on the outputs
    task automatic t_run(input int npairs, input int restart_at);
        logic [31:0] e0, e1;
        for (int p = 0; p < npairs; p++) begin
            e0 = rm_draw();
            e1 = rm_draw();
            chk(pair_valid == 1'b1, "R4 strobe", 32'(pair_valid), 1);
            if (rm_pos > 624 || (rm_pos <= 2 && p > 0) || p >= 300) begin
                chk(rand_first == e0, "R7 first", rand_first, e0);
                chk(rand_second == e1, "R7 second", rand_second, e1);
            end else begin
                chk(rand_first == e0, "R6 first", rand_first, e0);
                chk(rand_second == e1, "R6 second", rand_second, e1);
            end
            start = (p == restart_at);
            @(negedge clk);
            start = 1'b0;
            chk(pair_valid == 1'b0, (p > restart_at && restart_at >= 0) ? "R9 gap" : "R4 gap",
                32'(pair_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reseed_mid(input logic [31:0] s);
        seed_load  = 1'b1;
        seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk(pair_valid == 1'b0 && seeded == 1'b0, "R8 stopped", 32'({seeded, pair_valid}), 0);
            @(negedge clk);
        end
        for (int i = 0; i < 700 && !seeded; i++) @(negedge clk);
        chk(seeded == 1'b1, "R8 reseeded", 32'(seeded), 1);
        rm_seed(s);
        t_start_latency();
        t_run(20, -1);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_seed(32'd5489, 1'b1);
        t_start_latency();
        t_golden();
        t_run(330, 50);
        t_reseed_mid(32'd1234567);
        t_seed(32'd0, 1'b0);
        t_start_latency();
        t_run(12, 3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule